// File: doc/BRIEF.md
# Cassette Tape Record Modulator

This block turns a stream of bytes into the square-wave level that drives a cassette recorder's input. A one-cycle start pulse launches a record. The block first plays a long lead-in tone, whose length in tone cycles is taken from an input when the record starts. It then plays an asymmetric sync cycle. After that, each data byte is sent as frequency-coded bits, and the record closes with a checksum byte. Every bit is one full square-wave cycle. A zero uses short half cycles and a one uses half cycles twice as long.

Bytes arrive on a valid/ready stream, and a last flag marks the final data byte. The block accepts a byte only at the moment it needs one. If no byte is offered at that moment, it holds its output level until one arrives. The checksum starts at all ones and is folded with every accepted data byte by exclusive-or. It is then sent with the same bit coding. All timing is derived from one parameter, the number of clock ticks per microsecond.

Top module: `tape_record_modulator`

## Requirements
- R1: After a start pulse, the lead-in tone is 2*N half cycles of 650 us each, where N is the value of `hdr_cycles` when the record starts. A value of 0 is treated as 1.
- R2: The lead-in is followed by a sync cycle of one 200 us half cycle and then one 250 us half cycle.
- R3: A data bit is two equal half cycles: 250 us each for a 0, and 500 us each for a 1. A half cycle lasts us*TICKS_PER_US clock cycles. `tape_out` toggles at the end of every half cycle, so the first toggle comes one half-cycle length after the clock edge that takes the start pulse.
- R4: Bytes are sent in the order they are accepted, each with the most significant bit first.
- R5: After the byte accepted with `in_last` set, one checksum byte is sent. Its value is 8'hFF exclusive-ORed with every data byte of the record.
- R6: A byte is transferred on a clock edge where `in_ready` and `in_valid` are both high. `in_ready` is high only while the block needs a byte. If no byte is valid at that point, `tape_out` holds its level, and each cycle of waiting lengthens the following half cycle by one clock.
- R7: `busy` rises on the edge that takes a start pulse and falls on the edge of the final checksum toggle. On that same edge `done` goes high for exactly one cycle.
- R8: A start pulse while `busy` is high has no effect on the record in progress.
- R9: During and after reset, `tape_out`, `busy`, `done` and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a record |
| hdr_cycles | input | HDR_W | Lead-in length in full tone cycles, sampled at start |
| in_data | input | DATA_W | Byte offered for sending |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | The offered byte is the final data byte |
| in_ready | output | 1 | Block takes a byte on this edge if valid |
| tape_out | output | 1 | Square-wave level to the recorder |
| busy | output | 1 | A record is in progress |
| done | output | 1 | One-cycle pulse when a record has finished |

## Verification
The bench builds the block with TICKS_PER_US = 1, DATA_W = 8 and HDR_W = 16. With these values every half cycle lasts between 200 and 650 clocks, so complete records fit easily in a short run. Several records are run back to back, including a zero-length lead-in, an all-zero byte, an all-ones byte and random data. Stalls are exercised where the source withholds bytes at the moment they are requested. Each measured toggle-to-toggle interval is compared with a value the bench computes from the byte list and from the stall cycles it counts itself.

// File: rtl/tape_mod_pkg.sv
package tape_mod_pkg;

    // Half-cycle durations in microseconds
    localparam int unsigned LEADER_HALF_US = 650;
    localparam int unsigned SYNC_A_US      = 200;
    localparam int unsigned SYNC_B_US      = 250;
    localparam int unsigned ZERO_HALF_US   = 250;
    localparam int unsigned ONE_HALF_US    = 500;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEADER,
        PH_SYNC_A,
        PH_SYNC_B,
        PH_WAIT,
        PH_DATA,
        PH_CHECK
    } tape_phase_e;

    // Commands from the frame controller to the byte serializer
    typedef struct packed {
        logic clear;
        logic take_data;
        logic take_sum;
        logic advance;
    } ser_cmd_t;

    function automatic int unsigned us_to_ticks(input int unsigned us, input int unsigned tpu);
        return us * tpu;
    endfunction

endpackage

// File: rtl/tape_half_timer.sv
module tape_half_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    assign expire = active_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (load) begin
            cnt_q    <= len - CNT_W'(1);
            active_q <= 1'b1;
        end else if (expire) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/tape_byte_serializer.sv
module tape_byte_serializer
    import tape_mod_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ser_cmd_t          cmd,
    input  logic [DATA_W-1:0] data_in,
    output logic              cur_bit,
    output logic              next_bit,
    output logic              bit_last,
    output logic [DATA_W-1:0] sum
);

    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] sum_q;
    logic [IDX_W-1:0]  idx_q;

    assign cur_bit  = shift_q[DATA_W-1];
    assign next_bit = shift_q[DATA_W-2];
    assign bit_last = (idx_q == IDX_W'(DATA_W - 1));
    assign sum      = sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            sum_q   <= '1;
            idx_q   <= '0;
        end else begin
            if (cmd.clear) begin
                sum_q <= '1;
            end
            if (cmd.take_data) begin
                shift_q <= data_in;
                sum_q   <= sum_q ^ data_in;
                idx_q   <= '0;
            end else if (cmd.take_sum) begin
                shift_q <= sum_q;
                idx_q   <= '0;
            end else if (cmd.advance) begin
                shift_q <= {shift_q[DATA_W-2:0], 1'b0};
                idx_q   <= idx_q + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/tape_frame_fsm.sv
module tape_frame_fsm
    import tape_mod_pkg::*;
#(
    parameter int TICKS_PER_US = 1,
    parameter int CNT_W        = 10,
    parameter int HDR_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [HDR_W-1:0] hdr_cycles,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             in_msb,
    output logic             in_ready,
    input  logic             expire,
    input  logic             cur_bit,
    input  logic             next_bit,
    input  logic             bit_last,
    input  logic             sum_msb,
    output logic             tm_load,
    output logic [CNT_W-1:0] tm_len,
    output ser_cmd_t         cmd,
    output logic             tape_out,
    output logic             busy,
    output logic             done
);

    localparam int HL_W = HDR_W + 1;
    localparam logic [CNT_W-1:0] LEN_LEADER = CNT_W'(us_to_ticks(LEADER_HALF_US, TICKS_PER_US));
    localparam logic [CNT_W-1:0] LEN_SYNC_A = CNT_W'(us_to_ticks(SYNC_A_US, TICKS_PER_US));
    localparam logic [CNT_W-1:0] LEN_SYNC_B = CNT_W'(us_to_ticks(SYNC_B_US, TICKS_PER_US));
    localparam logic [CNT_W-1:0] LEN_ZERO   = CNT_W'(us_to_ticks(ZERO_HALF_US, TICKS_PER_US));
    localparam logic [CNT_W-1:0] LEN_ONE    = CNT_W'(us_to_ticks(ONE_HALF_US, TICKS_PER_US));

    function automatic logic [CNT_W-1:0] bit_len(input logic b);
        return b ? LEN_ONE : LEN_ZERO;
    endfunction

    tape_phase_e     phase_q, phase_d;
    logic            second_q, second_d;
    logic [HL_W-1:0] left_q, left_d;
    logic            last_q, last_d;
    logic            done_q, done_d;
    logic            level_q;
    logic            need_byte;
    logic [HDR_W-1:0] hdr_eff;

    assign hdr_eff   = (hdr_cycles == '0) ? HDR_W'(1) : hdr_cycles;
    assign need_byte = expire && ((phase_q == PH_SYNC_B) ||
                       (phase_q == PH_DATA && second_q && bit_last && !last_q));
    assign in_ready  = need_byte || (phase_q == PH_WAIT);
    assign busy      = (phase_q != PH_IDLE);
    assign done      = done_q;
    assign tape_out  = level_q;

    always_comb begin
        phase_d  = phase_q;
        second_d = second_q;
        left_d   = left_q;
        last_d   = last_q;
        done_d   = 1'b0;
        tm_load  = 1'b0;
        tm_len   = '0;
        cmd      = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    cmd.clear = 1'b1;
                    left_d    = {hdr_eff, 1'b0};
                    phase_d   = PH_LEADER;
                    tm_load   = 1'b1;
                    tm_len    = LEN_LEADER;
                end
            end
            PH_LEADER: begin
                if (expire) begin
                    tm_load = 1'b1;
                    if (left_q == HL_W'(1)) begin
                        phase_d = PH_SYNC_A;
                        tm_len  = LEN_SYNC_A;
                    end else begin
                        left_d = left_q - HL_W'(1);
                        tm_len = LEN_LEADER;
                    end
                end
            end
            PH_SYNC_A: begin
                if (expire) begin
                    phase_d = PH_SYNC_B;
                    tm_load = 1'b1;
                    tm_len  = LEN_SYNC_B;
                end
            end
            PH_DATA, PH_CHECK: begin
                if (expire) begin
                    if (!second_q) begin
                        second_d = 1'b1;
                        tm_load  = 1'b1;
                        tm_len   = bit_len(cur_bit);
                    end else begin
                        second_d = 1'b0;
                        if (!bit_last) begin
                            cmd.advance = 1'b1;
                            tm_load     = 1'b1;
                            tm_len      = bit_len(next_bit);
                        end else if (phase_q == PH_CHECK) begin
                            phase_d = PH_IDLE;
                            done_d  = 1'b1;
                        end else if (last_q) begin
                            cmd.take_sum = 1'b1;
                            phase_d      = PH_CHECK;
                            tm_load      = 1'b1;
                            tm_len       = bit_len(sum_msb);
                        end
                    end
                end
            end
            default: ;
        endcase
        if (in_ready) begin
            if (in_valid) begin
                cmd.take_data = 1'b1;
                last_d        = in_last;
                second_d      = 1'b0;
                phase_d       = PH_DATA;
                tm_load       = 1'b1;
                tm_len        = bit_len(in_msb);
            end else begin
                phase_d = PH_WAIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            second_q <= 1'b0;
            left_q   <= '0;
            last_q   <= 1'b0;
            done_q   <= 1'b0;
            level_q  <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            second_q <= second_d;
            left_q   <= left_d;
            last_q   <= last_d;
            done_q   <= done_d;
            if (expire) begin
                level_q <= ~level_q;
            end
        end
    end

endmodule

// File: rtl/tape_record_modulator.sv
module tape_record_modulator
    import tape_mod_pkg::*;
#(
    parameter int TICKS_PER_US = 50,
    parameter int DATA_W       = 8,
    parameter int HDR_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HDR_W-1:0]  hdr_cycles,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              tape_out,
    output logic              busy,
    output logic              done
);

    localparam int CNT_W = $clog2(LEADER_HALF_US * TICKS_PER_US + 1);

    logic              expire;
    logic              tm_load;
    logic [CNT_W-1:0]  tm_len;
    ser_cmd_t          cmd;
    logic              cur_bit;
    logic              next_bit;
    logic              bit_last;
    logic [DATA_W-1:0] sum;

    tape_half_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tm_load),
        .len    (tm_len),
        .expire (expire)
    );

    tape_byte_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .data_in  (in_data),
        .cur_bit  (cur_bit),
        .next_bit (next_bit),
        .bit_last (bit_last),
        .sum      (sum)
    );

    tape_frame_fsm #(
        .TICKS_PER_US (TICKS_PER_US),
        .CNT_W        (CNT_W),
        .HDR_W        (HDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .hdr_cycles (hdr_cycles),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_msb     (in_data[DATA_W-1]),
        .in_ready   (in_ready),
        .expire     (expire),
        .cur_bit    (cur_bit),
        .next_bit   (next_bit),
        .bit_last   (bit_last),
        .sum_msb    (sum[DATA_W-1]),
        .tm_load    (tm_load),
        .tm_len     (tm_len),
        .cmd        (cmd),
        .tape_out   (tape_out),
        .busy       (busy),
        .done       (done)
    );

endmodule

// File: rtl/tape_record_checker.sv
module tape_record_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic in_valid,
    input logic in_ready,
    input logic tape_out,
    input logic busy,
    input logic done
);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(tape_out));

    assert_ready_busy_R6: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> busy);

    assert_stall_keeps_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid && $past(in_ready && !in_valid)) |=> $stable(tape_out));

endmodule

bind tape_record_modulator tape_record_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tape_out (tape_out),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_tape_record_modulator.sv
`timescale 1ns/1ps
module tb_tape_record_modulator;

    localparam int TPU = 1;
    localparam int DW  = 8;
    localparam int HW  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [HW-1:0] hdr_cycles = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic          in_ready, tape_out, busy, done;

    tape_record_modulator #(.TICKS_PER_US(TPU), .DATA_W(DW), .HDR_W(HW)) dut (
        .clk(clk), .rst(rst), .start(start), .hdr_cycles(hdr_cycles),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .tape_out(tape_out), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    int          exp_len[$];
    string       exp_req[$];
    logic [7:0]  rec_data[4];

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic void push_half(input int us, input string req);
        exp_len.push_back(us * TPU);
        exp_req.push_back(req);
    endfunction

    function automatic void push_byte(input logic [7:0] b, input string req);
        for (int i = 7; i >= 0; i--) begin
            push_half(b[i] ? 500 : 250, req);
            push_half(b[i] ? 500 : 250, req);
        end
    endfunction

    task automatic run_record(input int h, input int n, input bit stall, input bit poke, input string dtag);
        logic [7:0] sum;
        int  k, last_t, acc, pend, idx, accepted, guard;
        bit  hs, prev, seen_done, poked, poke_chk;
        sum = 8'hFF;
        k = 0; acc = 0; pend = 0; idx = 0; accepted = 0; guard = 0;
        hs = 0; seen_done = 0; poked = 0; poke_chk = 0;
        exp_len.delete();
        exp_req.delete();
        for (int i = 0; i < 2 * ((h == 0) ? 1 : h); i++) push_half(650, "R1");
        push_half(200, "R2");
        push_half(250, "R2");
        for (int i = 0; i < n; i++) begin
            push_byte(rec_data[i], dtag);
            sum = sum ^ rec_data[i];
        end
        push_byte(sum, "R5");

        @(negedge clk);
        start = 1'b1;
        hdr_cycles = HW'(h);
        @(negedge clk);
        start = 1'b0;
        last_t = int'(cyc);
        prev = tape_out;
        check(busy === 1'b1, "R7", "busy after start", int'(busy), 1);

        while (!seen_done && guard < 60000) begin
            if (hs) begin
                idx++;
                accepted++;
            end
            if (poke_chk) begin
                check(busy === 1'b1, "R8", "busy after ignored start", int'(busy), 1);
                poke_chk = 0;
            end
            start = 1'b0;
            if (poke && !poked && k == 1) begin
                start = 1'b1;
                hdr_cycles = HW'(h + 5);
                poked = 1;
                poke_chk = 1;
            end
            in_valid = (idx < n) && !(stall && ($urandom % 3 == 0));
            in_data  = rec_data[(idx < n) ? idx : 0];
            in_last  = (idx == n - 1);
            #1;
            hs = in_ready && in_valid;
            acc += pend;
            pend = (in_ready && !in_valid) ? 1 : 0;
            @(negedge clk);
            guard++;
            if (tape_out !== prev) begin
                if (k < exp_len.size())
                    check(int'(cyc) - last_t == exp_len[k] + acc, exp_req[k], "half-cycle length",
                          int'(cyc) - last_t, exp_len[k] + acc);
                else
                    check(1'b0, "R5", "extra half cycle index", k, exp_len.size());
                k++;
                last_t = int'(cyc);
                acc = 0;
                prev = tape_out;
            end
            if (done) begin
                seen_done = 1;
                check(k == exp_len.size(), "R7", "half cycles before done", k, exp_len.size());
                check(busy === 1'b0, "R7", "busy low with done", int'(busy), 0);
            end
        end
        in_valid = 1'b0;
        start = 1'b0;
        check(seen_done, "R7", "done seen", int'(seen_done), 1);
        check(accepted == n, "R6", "bytes accepted", accepted, n);
        @(negedge clk);
        check(done === 1'b0, "R7", "done one cycle", int'(done), 0);
        check(in_ready === 1'b0, "R6", "ready low when idle", int'(in_ready), 0);
    endtask

    always @(posedge clk) begin
        if (cyc > 190000 && !finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL R7 watchdog: actual %0d expected %0d", cyc, 190000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(tape_out === 1'b0, "R9", "tape_out in reset", int'(tape_out), 0);
        check(busy === 1'b0, "R9", "busy in reset", int'(busy), 0);
        check(done === 1'b0, "R9", "done in reset", int'(done), 0);
        check(in_ready === 1'b0, "R9", "ready in reset", int'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tape_out === 1'b0 && busy === 1'b0, "R9", "idle after reset", int'(busy), 0);

        // zero-length lead-in treated as one cycle, all-zero byte
        rec_data[0] = 8'h00;
        run_record(0, 1, 1'b0, 1'b0, "R3");

        // all-ones byte then mixed byte, stalls and an ignored start
        rec_data[0] = 8'hFF;
        rec_data[1] = 8'hA5;
        run_record(1, 2, 1'b1, 1'b1, "R3");

        for (int r = 0; r < 3; r++) begin
            int h, n;
            h = int'($urandom % 2);
            n = 1 + int'($urandom % 2);
            for (int i = 0; i < 4; i++) rec_data[i] = 8'($urandom);
            run_record(h, n, 1'($urandom % 2), 1'b0, "R4");
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule